// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets clocked logic read and write an asynchronous static RAM with 16-bit words and two byte lanes. The host offers a request carrying an address, write data, a two-bit lane mask and a read/write flag. The controller accepts the request only while `ready` is high. It then runs the memory's active-low strobes for a fixed number of clock cycles, chosen so that the memory's access time and minimum pulse widths are met.

Reads return the captured word with a one-cycle `rd_valid` pulse. Writes return nothing. The memory's bidirectional data pins are split into an output value, an input value and a driver enable, so that a pad cell outside this block can form the tri-state bus. Each access is followed by an idle turnaround. A following access therefore never starts while the memory may still be driving the bus.

The timing is set by three parameters: `RD_WAIT` for the read access window, `WR_PULSE` for the write strobe width and `TURN` for the idle gap. The defaults (2, 1, 1) suit a 100 MHz clock and a memory that needs 12 ns of access time and 9 ns of write pulse.

Top module: `sram_ctrl`

## Requirements
- R1: After reset `ready` is 1, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: An accepted write holds `mem_cs_n` low and drives `mem_be_n` with the inverted mask. Mask bit 0 selects the low lane, data bits 7..0. Mask bit 1 selects the high lane, bits 15..8. `mem_we_n` stays low for exactly `WR_PULSE` cycles, starting at the edge of acceptance.
- R3: `mem_dq_oe` is high only while `mem_cs_n` is low and `mem_oe_n` is high. It covers the write strobe and the single hold cycle after `mem_we_n` rises.
- R4: `mem_oe_n` stays high during every write, so `mem_we_n` and `mem_oe_n` are never low together.
- R5: An accepted read holds `mem_cs_n` and `mem_oe_n` low, with `mem_be_n` set from the mask, for exactly `RD_WAIT` cycles. The data bus is sampled at the last of those edges.
- R6: `rd_valid` is a single-cycle pulse that rises `RD_WAIT` edges after the read is accepted. It never follows a write. Lanes of `rd_data` outside the mask read as 0.
- R7: Only the masked lanes of the addressed word change on a write. A write with mask 2'b00 leaves memory unchanged.
- R8: `ready` is low from acceptance for `RD_WAIT+TURN` cycles after a read and `WR_PULSE+1+TURN` cycles after a write. While `ready` is high, all strobes are high and the driver is off.
- R9: `mem_addr` does not change while `mem_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Lane mask, bit 0 = bits 7..0 |
| ready | output | 1 | Controller idle, request accepted when high |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data, unmasked lanes zero |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Lane enables, active low |
| mem_dq_o | output | DW | Data toward memory |
| mem_dq_i | input | DW | Data from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
A wrong state or counter shows up at the ports within one access. If a count is off, the strobe lengths or the `ready` busy time differ from their parameter values. A stuck state leaves `ready` low until the watchdog fires. A lane mix-up shows up when a partial write is read back later, or as a nonzero value in a masked lane of the data returned by the very next read. A bus conflict between the driver and an enabled memory output is flagged in the same cycle it occurs.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 1,
  parameter int TURN     = 1,
  localparam int NB      = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_be,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [NB-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe
);

  localparam int MAXC = (RD_WAIT > WR_PULSE) ? ((RD_WAIT > TURN) ? RD_WAIT : TURN)
                                             : ((WR_PULSE > TURN) ? WR_PULSE : TURN);
  localparam int CW = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_WHOLD, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  assign ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr <= req_addr;
          mem_be_n <= ~req_be;
          mem_cs_n <= 1'b0;
          cnt      <= '0;
          if (req_we) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            mem_dq_o  <= req_wdata;
            state     <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= S_RD;
          end
        end
        S_RD: if (cnt == CW'(RD_WAIT - 1)) begin
          for (int l = 0; l < NB; l++)
            rd_data[8*l +: 8] <= mem_be_n[l] ? 8'h00 : mem_dq_i[8*l +: 8];
          rd_valid <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_be_n <= '1;
          cnt      <= '0;
          state    <= S_TURN;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WR: if (cnt == CW'(WR_PULSE - 1)) begin
          mem_we_n <= 1'b1;
          cnt      <= '0;
          state    <= S_WHOLD;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WHOLD: begin
          mem_cs_n  <= 1'b1;
          mem_be_n  <= '1;
          mem_dq_oe <= 1'b0;
          state     <= S_TURN;
        end
        S_TURN: if (cnt == CW'(TURN - 1)) begin
          cnt   <= '0;
          state <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_drv_safe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  a_r4_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r2_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int RD_WAIT = 2, WR_PULSE = 1, TURN = 1;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_we = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_be = 0;
  logic        ready, rd_valid;
  logic [15:0] rd_data, mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i = 16'hA5A5;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  int tests = 0, fails = 0, cycles = 0;
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] expq [$];
  int we_run = 0, oe_run = 0;
  bit prev_valid = 0;

  always #4 clk = ~clk;

  sram_ctrl #(.AW(16), .DW(16), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .TURN(TURN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe(mem_dq_oe));

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] peek(input logic [15:0] a, input bit sh);
    if (sh) return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  // memory model: writes while strobes and driver are active, reads present data at negedge
  always @(negedge clk) begin
    logic [15:0] w;
    if (rst_n && !mem_cs_n && !mem_we_n && mem_dq_oe) begin
      w = peek(mem_addr, 0);
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l]) w[8*l +: 8] = mem_dq_o[8*l +: 8];
      mem[int'(mem_addr)] = w;
    end
    w = peek(mem_addr, 0);
    for (int l = 0; l < 2; l++)
      mem_dq_i[8*l +: 8] <= (!mem_cs_n && !mem_oe_n && !mem_be_n[l]) ? w[8*l +: 8] : 8'hA5;
  end

  // monitor: strobe widths, conflicts, scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        check(we_run == WR_PULSE, "R2 write strobe width", we_run, WR_PULSE);
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        check(oe_run == RD_WAIT, "R5 read window width", oe_run, RD_WAIT);
        oe_run = 0;
      end
      if (!mem_we_n && !mem_oe_n) check(0, "R4 oe low during write", 1, 0);
      if (mem_dq_oe && (!mem_oe_n || mem_cs_n)) check(0, "R3 driver conflict", 1, 0);
      if (rd_valid) begin
        if (prev_valid) check(0, "R6 valid longer than one cycle", 1, 0);
        if (expq.size() == 0) check(0, "R6 unexpected rd_valid", 1, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(rd_data == e, "R6/R7 read data", rd_data, e);
        end
      end
      prev_valid = rd_valid;
      if (cycles > 100000) begin
        check(0, "watchdog", cycles, 100000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    logic [15:0] s;
    while (!ready) @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    s = peek(a, 1);
    if (we) begin
      for (int l = 0; l < 2; l++) if (be[l]) s[8*l +: 8] = d[8*l +: 8];
      shadow[int'(a)] = s;
    end else begin
      for (int l = 0; l < 2; l++) if (!be[l]) s[8*l +: 8] = 8'h00;
      expq.push_back(s);
    end
    @(negedge clk);
    req = 0;
    check(!mem_cs_n && mem_be_n == ~be && mem_addr == a, "R2/R5 strobes and lanes",
          {14'd0, mem_be_n, mem_addr}, {14'd0, ~be, a});
    check(we ? (!mem_we_n && mem_oe_n) : (mem_we_n && !mem_oe_n), "R4/R5 direction strobes",
          {mem_we_n, mem_oe_n}, we ? 2'b01 : 2'b10);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    check(n == (we ? WR_PULSE + 1 + TURN : RD_WAIT + TURN), "R8 busy length", n,
          we ? WR_PULSE + 1 + TURN : RD_WAIT + TURN);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    check(ready && mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe && !rd_valid,
          "R1 reset state", {ready, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, rd_valid}, 8'hFC);
    rst_n = 1;
    @(negedge clk);
    access(1, 16'h0010, 16'hBEEF, 2'b11);
    access(0, 16'h0010, 16'h0000, 2'b11);   // R7 full word
    access(1, 16'h0010, 16'h1234, 2'b01);   // R7 low lane only
    access(0, 16'h0010, 16'h0000, 2'b11);
    access(0, 16'h0010, 16'h0000, 2'b10);   // R6 low lane masked to zero
    access(0, 16'h0010, 16'h0000, 2'b01);   // R6 high lane masked to zero
    access(1, 16'h0010, 16'hFFFF, 2'b00);   // R7 empty mask
    access(0, 16'h0010, 16'h0000, 2'b11);
    access(1, 16'h0010, 16'h7700, 2'b10);   // R7 high lane only
    access(0, 16'h0010, 16'h0000, 2'b11);
    access(1, 16'hFFFF, 16'hA5C3, 2'b11);
    access(0, 16'hFFFF, 16'h0000, 2'b11);
    access(0, 16'h0100, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++) access(1, 16'(i * 257), 16'(i * 4099 + 3), 2'b11);
    for (int i = 0; i < 8; i++) access(0, 16'(i * 257), 16'h0000, 2'(i % 4));
    for (int i = 0; i < 4; i++) begin
      access(1, 16'(i), 16'(16'hC0DE ^ i), 2'(i));
      access(0, 16'(i), 16'h0000, 2'b11);
    end
    repeat (RD_WAIT + 4) @(negedge clk);
    check(expq.size() == 0, "R6 missing read results", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule